// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block connects a fast bus clock domain to a small bank of registers that run on a 32.768 kHz low-power clock. A bus write is captured into a holding register and handed to the slow domain through a toggle handshake. It takes effect a fixed number of slow-clock cycles later. The bus side reports progress through four status flags: busy, ready-for-next, completed and error. An interrupt line combines three of these flags with a bus-speed enable register. The enable register is written directly in the bus domain and never waits for the slow clock.

Only one synchronized write can be in flight. A second synchronized write that arrives before the first commits is dropped and latches the sticky error flag. The error flag is cleared by a synchronized write of 1 to its bit in the status register. The completed flag clears when the status register is read.

The bus-side controller has two states, READY and BUSY. The transition READY→BUSY (accept) happens when a synchronized write arrives. The transition BUSY→READY (commit seen) happens when the returned acknowledge toggle is detected. The slow-side sequencer also has two states, IDLE and COUNT. The transition IDLE→COUNT (request seen) happens when the synchronized request toggle changes. The transition COUNT→IDLE (commit) happens after COMMIT_CYCLES slow cycles; on that edge the register file is written and the acknowledge toggle flips.

Top module: `lpw_write_sync`

## Requirements
- R1: After reset the status register reads 0x0200 (only the ready-for-next flag set), the enable register reads 0, and irq_o is low.
- R2: A write to any address other than the enable register (address 6), accepted while idle, makes the busy flag (bit 10) read 1 and the ready flag (bit 9) read 0 from the next bus cycle until commit.
- R3: A synchronized write reaches the slow register no sooner than COMMIT_CYCLES (4) slow-clock periods after the bus write, and within 12 periods. Afterwards a read of the written address (0–4 or 7) returns the data.
- R4: On commit, the completed flag (bit 8) is set. A read of the status register (address 5) clears it. Reads of other addresses leave it set.
- R5: A synchronized write arriving while busy is discarded and sets the error flag (bit 7). The write already in flight still commits with its own data.
- R6: The error flag is sticky. It is cleared only at the commit of a status-register write whose bit 7 is 1. A status write with bit 7 at 0 leaves it set, and every status write sets the completed flag.
- R7: A write to the enable register (address 6, bits 9, 8, 7) takes effect on the next bus cycle, even while busy. It never sets busy, completed or error.
- R8: irq_o equals (ready AND enable bit 9) OR (completed AND enable bit 8) OR (error AND enable bit 7).
- R9: Status bit positions are: bit 10 busy, bit 9 ready-for-next, bit 8 completed, bit 7 error. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus clock |
| lp_clk_i | input | 1 | Low-power (slow) clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write strobe, one bus cycle per write |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe; clears the completed flag when it addresses status |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Combinational read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is having the completed flag observable without the observation destroying it, because reading status clears the flag. The stimulus therefore sets only the completed enable bit and waits for irq_o before it reads status. It then reads status twice to show the set-then-clear order. The error flag plus each combination of flags is reached by deliberately issuing a second write within the commit window. The enable register is then swept through all eight values in three flag states, one of them taken while a write is still in flight.

// File: rtl/lpw_pkg.sv
package lpw_pkg;
    typedef enum logic {BUS_READY, BUS_BUSY} bus_state_e;
    typedef enum logic {LP_IDLE, LP_COUNT} lp_state_e;

    // status / enable bit positions (decoded by software)
    localparam int unsigned BUSY_BIT = 10;
    localparam int unsigned NEXT_BIT = 9;
    localparam int unsigned DONE_BIT = 8;
    localparam int unsigned ERR_BIT  = 7;
endpackage

// File: rtl/lpw_toggle_sync.sv
module lpw_toggle_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tgl_i,
    output logic pulse_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], tgl_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign pulse_o = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/lpw_bus_ctl.sv
module lpw_bus_ctl
    import lpw_pkg::*;
#(
    parameter int unsigned ADDR_W      = 3,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned STATUS_ADDR = 5,
    parameter int unsigned IEN_ADDR    = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] lp_rd_data_i,
    input  logic              ack_pulse_i,
    output logic              req_tgl_o,
    output logic [ADDR_W-1:0] hold_addr_o,
    output logic [DATA_W-1:0] hold_data_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STATUS_ADDR);
    localparam logic [ADDR_W-1:0] IEN_A  = ADDR_W'(IEN_ADDR);

    bus_state_e                 state_q, state_d;
    logic                       done_q, err_q, req_tgl_q;
    logic [NEXT_BIT:ERR_BIT]    ien_q;
    logic [ADDR_W-1:0]          hold_addr_q;
    logic [DATA_W-1:0]          hold_data_q;
    logic                       ien_wr, sync_wr, accept, collide, busy;
    logic                       stat_rd, err_clear;

    assign busy      = (state_q == BUS_BUSY);
    assign ien_wr    = wr_en_i && (wr_addr_i == IEN_A);
    assign sync_wr   = wr_en_i && (wr_addr_i != IEN_A);
    assign accept    = sync_wr && !busy;
    assign collide   = sync_wr && busy;
    assign stat_rd   = rd_en_i && (rd_addr_i == STAT_A);
    assign err_clear = ack_pulse_i && (hold_addr_q == STAT_A) && hold_data_q[ERR_BIT];

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= BUS_READY;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_READY: if (accept)      state_d = BUS_BUSY;
            BUS_BUSY:  if (ack_pulse_i) state_d = BUS_READY;
        endcase
    end

    // flags, holding register, enable register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_tgl_q   <= 1'b0;
            hold_addr_q <= '0;
            hold_data_q <= '0;
            done_q      <= 1'b0;
            err_q       <= 1'b0;
            ien_q       <= '0;
        end else begin
            if (accept) begin
                req_tgl_q   <= ~req_tgl_q;
                hold_addr_q <= wr_addr_i;
                hold_data_q <= wr_data_i;
            end
            if (ack_pulse_i)  done_q <= 1'b1;
            else if (stat_rd) done_q <= 1'b0;
            if (collide)        err_q <= 1'b1;
            else if (err_clear) err_q <= 1'b0;
            if (ien_wr) ien_q <= wr_data_i[NEXT_BIT:ERR_BIT];
        end
    end

    always_comb begin
        rd_data_o = lp_rd_data_i;
        if (rd_addr_i == STAT_A) begin
            rd_data_o           = '0;
            rd_data_o[BUSY_BIT] = busy;
            rd_data_o[NEXT_BIT] = !busy;
            rd_data_o[DONE_BIT] = done_q;
            rd_data_o[ERR_BIT]  = err_q;
        end else if (rd_addr_i == IEN_A) begin
            rd_data_o = '0;
            rd_data_o[NEXT_BIT:ERR_BIT] = ien_q;
        end
    end

    assign irq_o       = (!busy && ien_q[NEXT_BIT]) || (done_q && ien_q[DONE_BIT]) ||
                         (err_q && ien_q[ERR_BIT]);
    assign req_tgl_o   = req_tgl_q;
    assign hold_addr_o = hold_addr_q;
    assign hold_data_o = hold_data_q;

    // R2
    accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != IEN_A && !busy) |=> busy);
    // R4
    done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(done_q) |-> $past(ack_pulse_i));
    // R5
    collide_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i != IEN_A && busy) |=> err_q);
    // R6
    err_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(err_q) |-> $past(ack_pulse_i));
    // R7
    ien_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == IEN_A && !busy) |=> !busy);
endmodule

// File: rtl/lpw_lp_side.sv
module lpw_lp_side
    import lpw_pkg::*;
#(
    parameter int unsigned ADDR_W        = 3,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned COMMIT_CYCLES = 4,
    parameter int unsigned STATUS_ADDR   = 5,
    parameter int unsigned IEN_ADDR      = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_pulse_i,
    input  logic [ADDR_W-1:0] hold_addr_i,
    input  logic [DATA_W-1:0] hold_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              ack_tgl_o
);
    localparam int unsigned NUM_REGS = 2 ** ADDR_W;
    localparam int unsigned CNT_W    = (COMMIT_CYCLES > 1) ? $clog2(COMMIT_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(COMMIT_CYCLES - 1);

    lp_state_e               state_q, state_d;
    logic [CNT_W-1:0]        cnt_q;
    logic                    ack_q, commit;
    logic [NUM_REGS-1:0]     wr_ok;
    logic [DATA_W-1:0]       regs_q [NUM_REGS];

    // status and enable addresses have no slow-side storage
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_wmask
        if (i == STATUS_ADDR || i == IEN_ADDR) begin : g_none
            assign wr_ok[i] = 1'b0;
        end else begin : g_reg
            assign wr_ok[i] = 1'b1;
        end
    end

    assign commit = (state_q == LP_COUNT) && (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= LP_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LP_IDLE:  if (req_pulse_i) state_d = LP_COUNT;
            LP_COUNT: if (cnt_q == LAST) state_d = LP_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            ack_q <= 1'b0;
            for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
        end else begin
            if (state_q == LP_IDLE) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
            if (commit) begin
                ack_q <= ~ack_q;
                for (int i = 0; i < NUM_REGS; i++)
                    if (wr_ok[i] && hold_addr_i == ADDR_W'(i)) regs_q[i] <= hold_data_i;
            end
        end
    end

    assign rd_data_o = regs_q[rd_addr_i];
    assign ack_tgl_o = ack_q;

    // R5
    single_flight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == LP_COUNT) |-> !req_pulse_i);
endmodule

// File: rtl/lpw_write_sync.sv
module lpw_write_sync #(
    parameter int unsigned ADDR_W        = 3,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned COMMIT_CYCLES = 4,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned STATUS_ADDR   = 5,
    parameter int unsigned IEN_ADDR      = 6
) (
    input  logic              bus_clk_i,
    input  logic              lp_clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic              req_tgl, req_pulse, ack_tgl, ack_pulse;
    logic [ADDR_W-1:0] hold_addr;
    logic [DATA_W-1:0] hold_data, lp_rd_data;

    lpw_bus_ctl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STATUS_ADDR(STATUS_ADDR), .IEN_ADDR(IEN_ADDR)
    ) u_bus (
        .clk_i(bus_clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .lp_rd_data_i(lp_rd_data),
        .ack_pulse_i(ack_pulse), .req_tgl_o(req_tgl),
        .hold_addr_o(hold_addr), .hold_data_o(hold_data),
        .rd_data_o(rd_data_o), .irq_o(irq_o)
    );

    lpw_toggle_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i(lp_clk_i), .rst_ni(rst_ni), .tgl_i(req_tgl), .pulse_o(req_pulse)
    );

    lpw_toggle_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk_i(bus_clk_i), .rst_ni(rst_ni), .tgl_i(ack_tgl), .pulse_o(ack_pulse)
    );

    lpw_lp_side #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COMMIT_CYCLES(COMMIT_CYCLES),
        .STATUS_ADDR(STATUS_ADDR), .IEN_ADDR(IEN_ADDR)
    ) u_lp (
        .clk_i(lp_clk_i), .rst_ni(rst_ni), .req_pulse_i(req_pulse),
        .hold_addr_i(hold_addr), .hold_data_i(hold_data),
        .rd_addr_i(rd_addr_i), .rd_data_o(lp_rd_data), .ack_tgl_o(ack_tgl)
    );
endmodule

// File: tb/lpw_write_sync_bench.sv
module lpw_write_sync_bench;
    localparam int SLOW_PER = 34;

    logic        clk = 0, lp_clk = 0, rst_n = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [2:0]  wr_addr = 0, rd_addr = 0;
    logic [15:0] wr_data = 0;
    logic [15:0] rd_data;
    logic        irq;
    int          checks = 0, fails = 0;

    always #2 clk = ~clk;
    always #17 lp_clk = ~lp_clk;

    lpw_write_sync u_lpw_write_sync (
        .bus_clk_i(clk), .lp_clk_i(lp_clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1; rd_addr = a;
        #1 d = rd_data;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic wait_irq(output bit ok);
        ok = 0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (irq) begin ok = 1; break; end
        end
    endtask

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] d, v;
        bit ok;
        longint t0, el;
        logic [2:0] addrs [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd7};

        #50; @(negedge clk); rst_n = 1;
        rd(3'd5, v); chk("R1 status", v, 16'h0200);
        rd(3'd6, v); chk("R1 enable", v, 16'h0000);
        chk("R1 irq", irq, 0);

        wr(3'd6, 16'h0100);
        rd(3'd6, v); chk("R7 enable readback", v, 16'h0100);
        rd(3'd5, v); chk("R7 no busy/done", v, 16'h0200);

        for (int ai = 0; ai < 6; ai++) begin
            for (int k = 0; k < 2; k++) begin
                d = (16'h1111 * 16'(addrs[ai])) ^ (k == 1 ? 16'hA5C3 : 16'h0F0F);
                t0 = $time;
                wr(addrs[ai], d);
                rd(3'd5, v); chk("R2 R9 busy", v, 16'h0400);
                repeat (24) @(negedge clk);
                rd(3'd5, v); chk("R3 still busy", v, 16'h0400);
                wait_irq(ok);
                el = $time - t0;
                chk("R3 commit window", (ok && el >= 4*SLOW_PER && el <= 12*SLOW_PER), 1);
                rd(addrs[ai], v); chk("R3 data", v, d);
                rd(3'd5, v); chk("R4 R9 done set", v, 16'h0300);
                rd(3'd5, v); chk("R4 done cleared", v, 16'h0200);
            end
        end

        // collision
        wr(3'd1, 16'h1234);
        wr(3'd1, 16'hBEEF);
        wr(3'd6, 16'h0100);
        rd(3'd5, v); chk("R7 R5 busy+err, no done", v, 16'h0480);
        wait_irq(ok); chk("R5 commit", ok, 1);
        rd(3'd1, v); chk("R5 first data kept", v, 16'h1234);
        rd(3'd5, v); chk("R5 R9 err+done", v, 16'h0380);
        rd(3'd5, v); chk("R6 err sticky", v, 16'h0280);

        wr(3'd5, 16'h0000);
        wait_irq(ok);
        rd(3'd5, v); chk("R6 zero write keeps err", v, 16'h0380);
        wr(3'd5, 16'h0080);
        wait_irq(ok);
        rd(3'd5, v); chk("R6 err cleared", v, 16'h0300);
        rd(3'd5, v); chk("R6 idle", v, 16'h0200);

        // irq sweeps
        wr(3'd2, 16'h0001);
        wr(3'd2, 16'h0002);
        wait_irq(ok);
        rd(3'd5, v); chk("R5 setup", v, 16'h0380);
        for (int m = 0; m < 8; m++) begin
            wr(3'd6, 16'(m) << 7);
            @(negedge clk);
            chk("R8 ready+err", irq, ((m & 4) != 0) || ((m & 1) != 0));
        end
        wr(3'd3, 16'h0033);
        for (int m = 0; m < 8; m++) begin
            wr(3'd6, 16'(m) << 7);
            @(negedge clk);
            chk("R8 busy+err", irq, (m & 1) != 0);
        end
        wr(3'd6, 16'h0100);
        wait_irq(ok);
        for (int m = 0; m < 8; m++) begin
            wr(3'd6, 16'(m) << 7);
            @(negedge clk);
            chk("R8 all flags", irq, m != 0);
        end
        rd(3'd3, v); chk("R3 data after sweep", v, 16'h0033);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule